// File: doc/BRIEF.md
# Configurable Video Sync Pulse Generator

This block is the timing master for a standard-definition video path. A free-running pixel counter and line counter, both parameterised, step on every pixel clock. From their position the block drives an active-low horizontal sync, an active-low vertical sync, a data-valid strobe that marks the active pixel window, and a field flag. All four outputs are registered.

An 8-bit timing word sets the pulse shapes through four 2-bit codes. Each code maps to a non-linear count of pixel clocks. The HSYNC width code selects 1, 4, 16 or 128 clocks. The HSYNC-to-VSYNC delay code selects 0, 4, 8 or 18 clocks. The data-alignment code shifts the data-valid window by 0 to 3 clocks. The meaning of the VSYNC code depends on a mode input:

- **Width mode:** the VSYNC code gives a short pulse of 1, 4, 16 or 128 clocks.
- **Offset mode:** VSYNC spans whole lines, and one bit of the VSYNC code moves its rising edge half a line later.

The timing word and the mode are sampled at the end of each line. A change therefore never cuts a line or a pulse in two.

Top module: `vid_sync_master`

## Requirements
- R1: While `rst` is high at a clock edge, `hsync_n` and `vsync_n` go to 1, `data_valid` and `field_odd` go to 0, and the counters restart at line 0, pixel 0. On the same edge the timing word and the mode are sampled.
- R2: `timing_cfg[1:0]` selects the HSYNC width: codes 0, 1, 2 and 3 give 1, 4, 16 and 128 clocks. `hsync_n` is low in the output cycles that follow pixels 0 up to width-1 of every line. Each output lags its counter position by one clock.
- R3: `timing_cfg[3:2]` selects the vertical start delay: codes 0, 1, 2 and 3 give 0, 4, 8 and 18 clocks. `vsync_n` falls in the output cycle that follows pixel d of line 0.
- R4: In width mode (`timing_mode`=1), `timing_cfg[5:4]` selects a VSYNC low time of 1, 4, 16 or 128 clocks for codes 0 to 3.
- R5: In offset mode (`timing_mode`=0), `vsync_n` stays low until pixel d of line VS_LINES. If `timing_cfg[4]`=1, the end moves PIX_PER_LINE/2 clocks later. `timing_cfg[5]` has no effect in this mode.
- R6: `data_valid` is high after pixels ACT_START+a up to ACT_START+ACT_LEN+a-1, where a is `timing_cfg[7:6]` (0 to 3).
- R7: `field_odd` toggles on each clock edge where `vsync_n` falls.
- R8: The timing word and the mode are sampled only at the last pixel of a line and take effect from pixel 0 of the next line. A change in the middle of a line leaves the current line unchanged.
- R9: The pixel counter wraps at PIX_PER_LINE and the line counter wraps at LINES_PER_FRAME. Each frame therefore has exactly LINES_PER_FRAME HSYNC pulses and one VSYNC pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_cfg | input | 8 | Timing word: [1:0] HSYNC width, [3:2] vertical delay, [5:4] VSYNC code, [7:6] data alignment |
| timing_mode | input | 1 | 1 = width mode, 0 = offset (line-span) mode |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| data_valid | output | 1 | Active pixel window strobe |
| field_odd | output | 1 | Field flag, toggled at each VSYNC start |

## Verification
With delay code 0, the falling edges of HSYNC and VSYNC land on the same clock edge. The field toggle lands on that edge too. A timing-word update also coincides with the line and frame wrap on the last pixel of the frame. Directed frames use delay code 0 in both modes, and random timing words are written at random pixels, so both coincidences occur many times. Every output is compared, cycle by cycle, with a position model in the bench. The model applies the end-of-line sampling rule on its own.

// File: rtl/vid_sync_pkg.sv
package vid_sync_pkg;
  localparam int CODE_W = 2;
  localparam int CLK_W  = 8;

  typedef logic [CODE_W-1:0] code_t;

  // bit 7:6 align, 5:4 vsync code, 3:2 vertical delay, 1:0 hsync width
  typedef struct packed {
    code_t align;
    code_t vcode;
    code_t vdelay;
    code_t hwidth;
  } tcfg_t;

  typedef enum logic {MODE_OFFSET = 1'b0, MODE_WIDTH = 1'b1} tmode_t;

  function automatic logic [CLK_W-1:0] pulse_clks(code_t c);
    case (c)
      2'd0:    return 8'd1;
      2'd1:    return 8'd4;
      2'd2:    return 8'd16;
      default: return 8'd128;
    endcase
  endfunction

  function automatic logic [CLK_W-1:0] delay_clks(code_t c);
    case (c)
      2'd0:    return 8'd0;
      2'd1:    return 8'd4;
      2'd2:    return 8'd8;
      default: return 8'd18;
    endcase
  endfunction
endpackage

// File: rtl/vsm_timebase.sv
module vsm_timebase
  import vid_sync_pkg::*;
#(
  parameter int PIX_PER_LINE    = 864,
  parameter int LINES_PER_FRAME = 625,
  parameter int PIX_W           = 10,
  parameter int LIN_W           = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  tcfg_t            cfg_in,
  input  tmode_t           mode_in,
  output logic [PIX_W-1:0] pix_cnt,
  output logic [LIN_W-1:0] line_cnt,
  output tcfg_t            cfg_q,
  output tmode_t           mode_q
);
  localparam logic [PIX_W-1:0] PIX_LAST  = PIX_W'(PIX_PER_LINE - 1);
  localparam logic [LIN_W-1:0] LINE_LAST = LIN_W'(LINES_PER_FRAME - 1);

  logic line_end;
  assign line_end = (pix_cnt == PIX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_cnt  <= '0;
      line_cnt <= '0;
      cfg_q    <= cfg_in;
      mode_q   <= mode_in;
    end else if (line_end) begin
      pix_cnt  <= '0;
      line_cnt <= (line_cnt == LINE_LAST) ? '0 : line_cnt + 1'b1;
      cfg_q    <= cfg_in;
      mode_q   <= mode_in;
    end else begin
      pix_cnt  <= pix_cnt + 1'b1;
    end
  end

  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (rst)
    (pix_cnt <= PIX_LAST) && (line_cnt <= LINE_LAST));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pix_cnt != '0) |-> ($stable(cfg_q) && $stable(mode_q)));
endmodule

// File: rtl/vsm_decode.sv
module vsm_decode
  import vid_sync_pkg::*;
#(
  parameter int PIX_PER_LINE = 864,
  parameter int VS_LINES     = 2,
  parameter int ACT_START    = 132,
  parameter int ACT_LEN      = 720,
  parameter int PIX_W        = 10,
  parameter int POS_W        = 20
) (
  input  tcfg_t            cfg_q,
  input  tmode_t           mode_q,
  output logic [PIX_W-1:0] hs_width,
  output logic [POS_W-1:0] vs_start,
  output logic [POS_W-1:0] vs_end,
  output logic [PIX_W-1:0] de_start,
  output logic [PIX_W-1:0] de_stop
);
  localparam logic [POS_W-1:0] SPAN_BASE = POS_W'(VS_LINES * PIX_PER_LINE);
  localparam logic [POS_W-1:0] HALF_LINE = POS_W'(PIX_PER_LINE / 2);
  localparam logic [PIX_W-1:0] ACT_S     = PIX_W'(ACT_START);
  localparam logic [PIX_W-1:0] ACT_E     = PIX_W'(ACT_START + ACT_LEN);

  logic [POS_W-1:0] short_end, span_end;

  always_comb begin
    hs_width  = PIX_W'(pulse_clks(cfg_q.hwidth));
    vs_start  = POS_W'(delay_clks(cfg_q.vdelay));
    short_end = vs_start + POS_W'(pulse_clks(cfg_q.vcode));
    span_end  = SPAN_BASE + vs_start + (cfg_q.vcode[0] ? HALF_LINE : '0);
    vs_end    = (mode_q == MODE_WIDTH) ? short_end : span_end;
    de_start  = ACT_S + PIX_W'(cfg_q.align);
    de_stop   = ACT_E + PIX_W'(cfg_q.align);
  end
endmodule

// File: rtl/vsm_pulse_gen.sv
module vsm_pulse_gen #(
  parameter int PIX_PER_LINE = 864,
  parameter int PIX_W        = 10,
  parameter int LIN_W        = 10,
  parameter int POS_W        = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_cnt,
  input  logic [LIN_W-1:0] line_cnt,
  input  logic [PIX_W-1:0] hs_width,
  input  logic [POS_W-1:0] vs_start,
  input  logic [POS_W-1:0] vs_end,
  input  logic [PIX_W-1:0] de_start,
  input  logic [PIX_W-1:0] de_stop,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             data_valid,
  output logic             field_odd
);
  logic [POS_W-1:0] pos;
  logic hs_on, vs_on, de_on;

  assign pos   = POS_W'(line_cnt) * POS_W'(PIX_PER_LINE) + POS_W'(pix_cnt);
  assign hs_on = (pix_cnt < hs_width);
  assign vs_on = (pos >= vs_start) && (pos < vs_end);
  assign de_on = (pix_cnt >= de_start) && (pix_cnt < de_stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n    <= 1'b1;
      vsync_n    <= 1'b1;
      data_valid <= 1'b0;
      field_odd  <= 1'b0;
    end else begin
      hsync_n    <= ~hs_on;
      vsync_n    <= ~vs_on;
      data_valid <= de_on;
      if (vs_on && vsync_n) field_odd <= ~field_odd;
    end
  end

  assert_hs_start_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> ($past(pix_cnt) == '0));

  assert_vs_start_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> ($past(pos) == $past(vs_start)));

  assert_de_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> ($past(pix_cnt) == $past(de_start)));

  assert_field_flip_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> (field_odd != $past(field_odd)));
endmodule

// File: rtl/vid_sync_master.sv
module vid_sync_master
  import vid_sync_pkg::*;
#(
  parameter int PIX_PER_LINE    = 864,
  parameter int LINES_PER_FRAME = 625,
  parameter int VS_LINES        = 2,
  parameter int ACT_START       = 132,
  parameter int ACT_LEN         = 720
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] timing_cfg,
  input  logic       timing_mode,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic       data_valid,
  output logic       field_odd
);
  localparam int PIX_W = $clog2(PIX_PER_LINE + 1);
  localparam int LIN_W = $clog2(LINES_PER_FRAME);
  localparam int POS_W = $clog2(PIX_PER_LINE * (LINES_PER_FRAME + 1));

  tcfg_t            cfg_in, cfg_q;
  tmode_t           mode_in, mode_q;
  logic [PIX_W-1:0] pix_cnt, hs_width, de_start, de_stop;
  logic [LIN_W-1:0] line_cnt;
  logic [POS_W-1:0] vs_start, vs_end;

  assign cfg_in  = tcfg_t'(timing_cfg);
  assign mode_in = tmode_t'(timing_mode);

  vsm_timebase #(
    .PIX_PER_LINE(PIX_PER_LINE), .LINES_PER_FRAME(LINES_PER_FRAME),
    .PIX_W(PIX_W), .LIN_W(LIN_W)
  ) u_timebase (
    .clk(clk), .rst(rst), .cfg_in(cfg_in), .mode_in(mode_in),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .cfg_q(cfg_q), .mode_q(mode_q)
  );

  vsm_decode #(
    .PIX_PER_LINE(PIX_PER_LINE), .VS_LINES(VS_LINES),
    .ACT_START(ACT_START), .ACT_LEN(ACT_LEN),
    .PIX_W(PIX_W), .POS_W(POS_W)
  ) u_decode (
    .cfg_q(cfg_q), .mode_q(mode_q), .hs_width(hs_width),
    .vs_start(vs_start), .vs_end(vs_end),
    .de_start(de_start), .de_stop(de_stop)
  );

  vsm_pulse_gen #(
    .PIX_PER_LINE(PIX_PER_LINE), .PIX_W(PIX_W), .LIN_W(LIN_W), .POS_W(POS_W)
  ) u_pulse (
    .clk(clk), .rst(rst), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .hs_width(hs_width), .vs_start(vs_start), .vs_end(vs_end),
    .de_start(de_start), .de_stop(de_stop),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .data_valid(data_valid), .field_odd(field_odd)
  );
endmodule

// File: tb/vid_sync_master_bench.sv
module vid_sync_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PPL = 160;
  localparam int LPF = 6;
  localparam int VSL = 2;
  localparam int AS  = 130;
  localparam int AL  = 20;
  localparam int FRAME = PPL * LPF;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg = 8'h00;
  logic mode = 1'b1;
  logic hsync_n, vsync_n, data_valid, field_odd;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit live = 0;
  bit tag_r8 = 0;

  int mp, ml;
  logic [7:0] mcfg;
  logic mmode;
  logic e_hs, e_vs, e_dv, e_fld;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_sync_master #(
    .PIX_PER_LINE(PPL), .LINES_PER_FRAME(LPF), .VS_LINES(VSL),
    .ACT_START(AS), .ACT_LEN(AL)
  ) u_vid_sync_master (
    .clk(clk), .rst(rst), .timing_cfg(cfg), .timing_mode(mode),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .data_valid(data_valid), .field_odd(field_odd)
  );

  function automatic int pulse_of(logic [1:0] c);
    case (c) 2'd0: return 1; 2'd1: return 4; 2'd2: return 16; default: return 128; endcase
  endfunction

  function automatic int delay_of(logic [1:0] c);
    case (c) 2'd0: return 0; 2'd1: return 4; 2'd2: return 8; default: return 18; endcase
  endfunction

  // position model: outputs lag the counter position by one clock
  always @(posedge clk) begin
    if (rst) begin
      mp = 0; ml = 0; mcfg = cfg; mmode = mode;
      e_hs = 1; e_vs = 1; e_dv = 0; e_fld = 0;
    end else begin
      int pos, d, vend, a;
      bit vlow;
      pos  = ml * PPL + mp;
      d    = delay_of(mcfg[3:2]);
      vend = mmode ? d + pulse_of(mcfg[5:4]) : VSL * PPL + d + (mcfg[4] ? PPL / 2 : 0);
      vlow = (pos >= d) && (pos < vend);
      if (vlow && e_vs) e_fld = ~e_fld;
      e_vs = ~vlow;
      e_hs = !(mp < pulse_of(mcfg[1:0]));
      a    = int'(mcfg[7:6]);
      e_dv = (mp >= AS + a) && (mp < AS + AL + a);
      if (mp == PPL - 1) begin
        mp = 0; mcfg = cfg; mmode = mode;
        ml = (ml == LPF - 1) ? 0 : ml + 1;
      end else mp = mp + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && !rst && !done) begin
      check(hsync_n == e_hs, tag_r8 ? "R8 hsync" : "R2 hsync", hsync_n, e_hs);
      check(vsync_n == e_vs, mmode ? "R3/R4 vsync" : "R3/R5 vsync", vsync_n, e_vs);
      check(data_valid == e_dv, "R6 data_valid", data_valid, e_dv);
      check(field_odd == e_fld, "R7 field", field_odd, e_fld);
    end
  end

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; mode = m;
    repeat (2) @(negedge clk);
    // R1: reset values seen while reset is held
    check(hsync_n == 1'b1, "R1 hsync_n", hsync_n, 1);
    check(vsync_n == 1'b1, "R1 vsync_n", vsync_n, 1);
    check(data_valid == 1'b0, "R1 data_valid", data_valid, 0);
    check(field_odd == 1'b0, "R1 field_odd", field_odd, 0);
    rst = 1'b0;
  endtask

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R9: one frame holds LPF hsync pulses and one vsync pulse
  task automatic count_frame();
    int hs_f = 0, vs_f = 0;
    logic ph = hsync_n, pv = vsync_n;
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      if (ph && !hsync_n) hs_f++;
      if (pv && !vsync_n) vs_f++;
      ph = hsync_n; pv = vsync_n;
    end
    check(hs_f == LPF, "R9 hsync per frame", hs_f, LPF);
    check(vs_f == 1, "R9 vsync per frame", vs_f, 1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2718);
    live = 1;
    cfg = 8'h00;
    do_reset(1'b1);
    // R2/R3/R4 directed: walk each code in width mode, delay code 0 included
    for (int c = 0; c < 4; c++) begin
      cfg = {2'(c), 2'(3 - c), 2'(c), 2'(c)};
      run_cycles(2 * FRAME);
    end
    // R5: offset mode, half-line bit off and on, upper bit toggled (no effect)
    do_reset(1'b0);
    for (int c = 0; c < 4; c++) begin
      cfg = {2'(c), 2'(c), 2'(c), 2'(3 - c)};
      run_cycles(2 * FRAME);
    end
    count_frame();
    // R8: mid-line change while hsync is low keeps the running line intact
    do_reset(1'b1);
    cfg = 8'h02;
    run_cycles(PPL + 5);
    tag_r8 = 1;
    cfg = 8'hC0;
    run_cycles(PPL);
    check(hsync_n == e_hs, "R8 after line start", hsync_n, e_hs);
    tag_r8 = 0;
    count_frame();
    // random timing words at random pixels; mode changed only with a reset
    for (int f = 0; f < 24; f++) begin
      if (f % 6 == 0) do_reset(1'($urandom));
      for (int k = 0; k < 4; k++) begin
        cfg = 8'($urandom);
        run_cycles(1 + ($urandom % (FRAME / 2)));
      end
    end
    count_frame();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule